// File: doc/BRIEF.md
# Weighted Pseudorandom Test-Vector Source

This block produces a fresh test vector on every enabled clock for a self-test session. A free-running maximal-length shift register with linear feedback supplies bits that are 1 about half the time. A small combinational network then biases each output line on its own: a line can pass a raw bit, the AND of two register bits (a 1 about a quarter of the time), or the OR of two register bits (a 1 about three quarters of the time). Biased lines help reach logic such as wide AND or OR gates, where unbiased vectors almost always hold one input at the value that blocks the others.

The per-line bias choices sit in a run-time weight register that is written through a simple write port while the generator is stopped. A test controller can therefore run several sessions in turn, each with its own weight set, without changing the hardware. A seed port restarts the sequence from a known state so that each session can be repeated exactly.

Top module: `weighted_pattern_gen`

## Requirements
- R1: After reset the shift-register state is 1 (only bit 0 set) and every weight code is 00, so with defaults the vector reads 8'h01.
- R2: Each clock with `genEn` high and `seedLoad` low advances the state once: the state shifts toward the MSB and the new bit 0 is the XOR of the state bits selected by `FB_MASK` (default bits 9 and 6, a period of 1023 non-zero states); the state is never zero.
- R3: `seedLoad` takes priority over `genEn`: the state becomes `seedVal` on the next clock, or 1 when `seedVal` is zero.
- R4: With `genEn` and `seedLoad` both low the state and the vector hold.
- R5: `wtWrEn` writes `wtWrData` into the weight register only on a clock where `genEn` is low; a write while `genEn` is high is ignored.
- R6: Line i uses a primary bit a = i mod LFSR_W and a partner bit b = (i+3) mod LFSR_W; its weight code is `wtWrData[2i+1:2i]`. Code 00 drives the line with bit a.
- R7: Code 01 drives line i with (bit a AND bit b), a probability of 1/4.
- R8: Code 10 drives line i with (bit a OR bit b), a probability of 3/4; code 11 behaves as code 00.
- R9: Over one full period the count of ones on each line is within period/32 of period times its weight probability (1/4, 1/2, 3/4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| genEn | input | 1 | Advance the sequence by one step per clock |
| seedLoad | input | 1 | Load the state from `seedVal` |
| seedVal | input | LFSR_W | Seed value (zero is replaced by 1) |
| wtWrEn | input | 1 | Write strobe for the weight register |
| wtWrData | input | 2*OUT_W | Two-bit weight code per output line |
| pattern | output | OUT_W | Weighted test vector |

## Verification
The vector is compared against a behavioural model on every clock under all-raw weights, a mixed set of AND, OR, raw and code-11 lines, and a second set that swaps the biases, so a wrong tap pair or a swapped AND/OR shows up as a bit mismatch. Stopped stretches, seed loads asserted together with the enable, a zero seed, and a weight write attempted while running distinguish the priority and hold rules. A full-period run counts ones per line, which tells a true quarter or three-quarter bias from an unbiased line and catches a feedback error that shortens the period.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    W_HALF    = 2'b00,
    W_QUARTER = 2'b01,
    W_THREEQ  = 2'b10,
    W_SPARE   = 2'b11
  } weightCode_e;

  typedef struct packed {
    logic seedLd;
    logic step;
    logic wtWr;
  } wpgStrobes_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic        genEn,
  input  logic        seedLoad,
  input  logic        wtWrEn,
  output wpgStrobes_t strobes
);
  always_comb begin
    strobes.seedLd = seedLoad;
    strobes.step   = genEn & ~seedLoad;
    strobes.wtWr   = wtWrEn & ~genEn;
  end
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int LFSR_W = 10,
  parameter int OUT_W = 8,
  parameter logic [LFSR_W-1:0] FB_MASK = 10'h240,
  parameter int PARTNER_OFS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wpgStrobes_t         strobes,
  input  logic [LFSR_W-1:0]   seedVal,
  input  logic [2*OUT_W-1:0]  wtWrData,
  output logic [LFSR_W-1:0]   lfsrState,
  output logic [2*OUT_W-1:0]  weights,
  output logic [OUT_W-1:0]    pattern
);
  localparam logic [LFSR_W-1:0] ONE = LFSR_W'(1);

  logic feedback;
  logic [LFSR_W-1:0] seedSafe;

  assign feedback = ^(lfsrState & FB_MASK);
  assign seedSafe = (seedVal == '0) ? ONE : seedVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsrState <= ONE;
    end else if (strobes.seedLd) begin
      lfsrState <= seedSafe;
    end else if (strobes.step) begin
      lfsrState <= {lfsrState[LFSR_W-2:0], feedback};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weights <= '0;
    end else if (strobes.wtWr) begin
      weights <= wtWrData;
    end
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    localparam int PRIM = i % LFSR_W;
    localparam int PART = (i + PARTNER_OFS) % LFSR_W;
    weightCode_e code;
    logic primBit, partBit;
    assign code    = weightCode_e'(weights[2*i +: 2]);
    assign primBit = lfsrState[PRIM];
    assign partBit = lfsrState[PART];
    always_comb begin
      case (code)
        W_QUARTER: pattern[i] = primBit & partBit;
        W_THREEQ:  pattern[i] = primBit | partBit;
        default:   pattern[i] = primBit;
      endcase
    end
  end
endmodule

// File: rtl/weighted_pattern_gen.sv
module weighted_pattern_gen
  import wpg_pkg::*;
#(
  parameter int LFSR_W = 10,
  parameter int OUT_W = 8,
  parameter logic [LFSR_W-1:0] FB_MASK = 10'h240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               genEn,
  input  logic               seedLoad,
  input  logic [LFSR_W-1:0]  seedVal,
  input  logic               wtWrEn,
  input  logic [2*OUT_W-1:0] wtWrData,
  output logic [OUT_W-1:0]   pattern
);
  wpgStrobes_t strobes;
  logic [LFSR_W-1:0]  lfsrState;
  logic [2*OUT_W-1:0] weights;

  wpg_ctrl u_ctrl (
    .genEn(genEn),
    .seedLoad(seedLoad),
    .wtWrEn(wtWrEn),
    .strobes(strobes)
  );

  wpg_datapath #(
    .LFSR_W(LFSR_W),
    .OUT_W(OUT_W),
    .FB_MASK(FB_MASK)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .strobes(strobes),
    .seedVal(seedVal),
    .wtWrData(wtWrData),
    .lfsrState(lfsrState),
    .weights(weights),
    .pattern(pattern)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int LFSR_W = 10,
  parameter int OUT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               genEn,
  input logic               seedLoad,
  input logic [LFSR_W-1:0]  seedVal,
  input logic [LFSR_W-1:0]  lfsrState,
  input logic [2*OUT_W-1:0] weights,
  input logic [OUT_W-1:0]   pattern
);
  // R2: state never reaches the all-zero lock-up value
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsrState != '0);

  // R2: an enabled step shifts the old state up by one place
  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (genEn && !seedLoad) |=> lfsrState[LFSR_W-1:1] == $past(lfsrState[LFSR_W-2:0]));

  // R3: non-zero seed is taken as given, even with the enable high
  a_r3_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    (seedLoad && seedVal != '0) |=> lfsrState == $past(seedVal));

  // R3: zero seed becomes 1
  a_r3_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (seedLoad && seedVal == '0) |=> lfsrState == LFSR_W'(1));

  // R4: stopped generator holds its state
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!genEn && !seedLoad) |=> $stable(lfsrState));

  // R5: weights cannot change while running
  a_r5_weights_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    genEn |=> $stable(weights));

  // R4: vector is steady when state and weights are
  a_r4_pattern_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lfsrState) && $stable(weights)) |-> $stable(pattern));
endmodule

bind weighted_pattern_gen wpg_checker #(
  .LFSR_W(LFSR_W),
  .OUT_W(OUT_W)
) u_wpg_checker (
  .clk(clk),
  .rst_n(rst_n),
  .genEn(genEn),
  .seedLoad(seedLoad),
  .seedVal(seedVal),
  .lfsrState(lfsrState),
  .weights(weights),
  .pattern(pattern)
);

// File: tb/tb_weighted_pattern_gen.sv
`timescale 1ns/1ps
module tb_weighted_pattern_gen;
  localparam int LW = 10;
  localparam int OW = 8;
  localparam int PERIOD = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic genEn = 1'b0;
  logic seedLoad = 1'b0;
  logic [LW-1:0] seedVal = '0;
  logic wtWrEn = 1'b0;
  logic [2*OW-1:0] wtWrData = '0;
  logic [OW-1:0] pattern;

  int nTests = 0;
  int nFail = 0;
  int mState = 1;
  int mWts [OW];
  int ones [OW];

  always #2 clk = ~clk;

  weighted_pattern_gen dut (
    .clk(clk), .rst_n(rst_n), .genEn(genEn), .seedLoad(seedLoad),
    .seedVal(seedVal), .wtWrEn(wtWrEn), .wtWrData(wtWrData), .pattern(pattern)
  );

  function automatic int bitOf(int s, int k);
    return (s >> k) & 1;
  endfunction

  function automatic logic [OW-1:0] expPattern();
    logic [OW-1:0] p;
    for (int i = 0; i < OW; i++) begin
      int a = bitOf(mState, i % LW);
      int b = bitOf(mState, (i + 3) % LW);
      case (mWts[i])
        1: p[i] = 1'(a & b);
        2: p[i] = 1'(a | b);
        default: p[i] = 1'(a);
      endcase
    end
    return p;
  endfunction

  task automatic compare(string tag);
    logic [OW-1:0] e = expPattern();
    nTests++;
    if (pattern !== e) begin
      nFail++;
      $display("FAIL %s: pattern=%h expected=%h", tag, pattern, e);
    end
  endtask

  // one clock: model follows the inputs seen at the edge, then compare
  task automatic tick(string tag);
    @(posedge clk);
    if (seedLoad) mState = (seedVal == 0) ? 1 : int'(seedVal);
    else if (genEn) mState = ((mState << 1) | (bitOf(mState, 9) ^ bitOf(mState, 6))) & 1023;
    if (wtWrEn && !genEn)
      for (int i = 0; i < OW; i++) mWts[i] = int'(wtWrData[2*i +: 2]);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [2*OW-1:0] packW(int c0, int c1, int c2, int c3,
                                            int c4, int c5, int c6, int c7);
    return {2'(c7), 2'(c6), 2'(c5), 2'(c4), 2'(c3), 2'(c2), 2'(c1), 2'(c0)};
  endfunction

  task automatic checkCount(int line, int expOnes);
    nTests++;
    if (ones[line] < expOnes - PERIOD/32 || ones[line] > expOnes + PERIOD/32) begin
      nFail++;
      $display("FAIL R9 line %0d: ones=%0d expected=%0d", line, ones[line], expOnes);
    end
  endtask

  initial begin
    #40000;
    nFail++;
    $display("FAIL watchdog: expired=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < OW; i++) mWts[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state and default weights
    nTests++;
    if (pattern !== 8'h01) begin
      nFail++;
      $display("FAIL R1: pattern=%h expected=01", pattern);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 / R6: run with raw weights
    genEn = 1'b1;
    repeat (40) tick("R2_R6");

    // R4: stopped
    genEn = 1'b0;
    repeat (5) tick("R4");

    // R5 / R7 / R8: write mixed weights while stopped
    wtWrEn = 1'b1;
    wtWrData = packW(1, 2, 0, 3, 1, 2, 1, 2);
    tick("R5_write");
    wtWrEn = 1'b0;
    genEn = 1'b1;
    repeat (30) tick("R7_R8");

    // R5: write attempted while running is ignored
    wtWrEn = 1'b1;
    wtWrData = packW(2, 1, 2, 1, 2, 1, 2, 1);
    repeat (3) tick("R5_ignored");
    wtWrEn = 1'b0;
    genEn = 1'b0;
    tick("R5_ignored");

    // R3: seed load wins over enable, zero seed becomes 1
    genEn = 1'b1;
    seedLoad = 1'b1;
    seedVal = 10'h2A5;
    tick("R3_seed");
    seedVal = '0;
    tick("R3_zero");
    seedLoad = 1'b0;
    repeat (10) tick("R3_after");

    // R9: full period with a second weight set
    genEn = 1'b0;
    wtWrEn = 1'b1;
    wtWrData = packW(2, 2, 1, 1, 0, 0, 3, 1);
    tick("R9_write");
    wtWrEn = 1'b0;
    genEn = 1'b1;
    for (int i = 0; i < OW; i++) ones[i] = 0;
    for (int c = 0; c < PERIOD; c++) begin
      tick("R9_run");
      for (int i = 0; i < OW; i++) ones[i] += int'(pattern[i]);
    end
    checkCount(0, 767);
    checkCount(1, 767);
    checkCount(2, 256);
    checkCount(3, 256);
    checkCount(4, 512);
    checkCount(5, 512);
    checkCount(6, 512);
    checkCount(7, 256);
    genEn = 1'b0;
    tick("R4_end");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule